// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block times the chip-select access cycles of an external memory bus. An internal requester raises a one-cycle request together with a read/write flag, a burst flag, a burst length and the wait configuration. The sequencer then drives the active-low chip enable and the output or write enable strobes, steps a low-address beat counter, and reports the end of the access with a one-cycle done pulse. Address and data multiplexing, the internal bus protocol and the configuration registers are outside this block.

There are two timing modes. In page mode the waits are fixed: the first beat inserts the first-wait count and every later burst beat inserts the shorter page-wait count. In ready mode one shared pin becomes an input from the external device. After a programmed wait the sequencer samples a two-flop synchronized copy of that pin and holds the access until it is seen high. The same pin is otherwise an active-low ACK output, or it is left undriven. Bit 0 of the first-wait field selects between these two pin behaviours. Because that bit also sits in the ready-mode count, ready-mode waits are always even.

Top module: `ebus_wait_seq`

## Requirements
- R1: After reset the strobes `ce_n_o`, `oe_n_o`, `we_n_o` and `ack_n_o` are high, `done_o`, `reject_o` and `ack_oe_o` are low, and `beat_addr_o` is 0.
- R2: In page mode the first beat of every access keeps `ce_n_o` low for `first_wait_i`+1 cycles. The cycle after the accepting edge is the first of them.
- R3: In page mode, with `burst_i`=1, the access has `burst_len_i`+1 beats, and each beat after the first adds `page_wait_i`+1 low cycles of `ce_n_o`. With `burst_i`=0 the access has a single beat, whatever `burst_len_i` holds.
- R4: `beat_addr_o` is 0 in the first beat of an access and rises by exactly one per later beat, so it reads the beat count minus one at the end of the access.
- R5: A read (`write_i`=0) holds `oe_n_o` low and a write holds `we_n_o` low on every cycle that `ce_n_o` is low. In the cycle after the last low cycle all three strobes are high and `done_o` is high for exactly one cycle.
- R6: The shared pin is driven (`ack_oe_o`=1) only in page mode with bit 0 of the first-wait field set. Then `ack_n_o` is low for one cycle, the last cycle of each beat. In page mode with that bit clear, and in ready mode, `ack_oe_o` is 0 and no ACK pulse occurs.
- R7: In ready mode, with the pin already high, `ce_n_o` is low for W+1 cycles, where W = {`page_wait_i`, `first_wait_i`[3:1], 0}. W therefore takes only the even values 0 to 62.
- R8: `rdy_pin_i` passes through two flops. When the pin rises after the wait has elapsed, `ce_n_o` stays low through the second cycle after the edge that first captures the high pin.
- R9: In ready mode the pin is not acted on before W cycles have elapsed. An early ready does not shorten the access below W+1 cycles.
- R10: A ready-mode request with `burst_i`=1 is refused. `reject_o` is high for one cycle, the cycle after the request, and no strobe or `done_o` follows.
- R11: A request that arrives while an access is in progress is ignored. It neither alters the running access nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle access request, taken only when idle |
| burst_i | input | 1 | Burst access flag |
| burst_len_i | input | LEN_W | Burst beats minus one |
| write_i | input | 1 | 1 = write, 0 = read |
| ready_mode_i | input | 1 | 1 = ready mode, 0 = page mode |
| first_wait_i | input | FW_W | First-beat wait count; bit 0 selects the pin behaviour |
| page_wait_i | input | PW_W | Later-beat wait count; high part of the ready-mode count |
| rdy_pin_i | input | 1 | Asynchronous ready from the external device |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| beat_addr_o | output | LEN_W | Low-address beat counter |
| ack_n_o | output | 1 | ACK value for the shared pin, active low |
| ack_oe_o | output | 1 | Drive enable for the shared pin |
| done_o | output | 1 | One-cycle end-of-access pulse |
| reject_o | output | 1 | One-cycle pulse for a refused burst in ready mode |

## Verification
The bench targets several mistakes. It runs bursts whose later beats use a page wait different from the first wait, which exposes a design that reloads the wrong count or loses the first beat's length. It uses a large ready-mode count with both wait fields at their maximum and one whose low first-wait bit is set, which catches a count that keeps that bit or drops the page-wait part. It raises ready early and raises it late, which exposes a design that samples before the wait has elapsed or skips a synchronizer stage. It also tries a burst in ready mode, a request during a busy access, and a single access with a non-zero length, which catch a burst that is started anyway, a restarted access, and extra beats.

// File: rtl/ebus_wait_seq_pkg.sv
package ebus_wait_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ACCESS = 2'd1,
      SEQ_DONE   = 2'd2
   } seq_state_e;

   function automatic int unsigned rdy_count_width(input int unsigned fw_w,
                                                   input int unsigned pw_w);
      return fw_w + pw_w;
   endfunction

endpackage

// File: rtl/ebus_rdy_sync.sv
module ebus_rdy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ebus_rdy_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= async_i;
               chain_q[1] <= chain_q[0];
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], async_i};
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ebus_wait_cnt.sv
module ebus_wait_cnt #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("ebus_wait_cnt: CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ebus_beat_cnt.sv
module ebus_beat_cnt #(
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic [LEN_W-1:0] last_i,
   output logic [LEN_W-1:0] beat_o,
   output logic             at_last_o
);

   logic [LEN_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (clear_i) begin
         beat_q <= '0;
      end else if (step_i) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   assign beat_o    = beat_q;
   assign at_last_o = (beat_q == last_i);

endmodule

// File: rtl/ebus_wait_seq.sv
module ebus_wait_seq
   import ebus_wait_seq_pkg::*;
#(
   parameter int unsigned LEN_W       = 3,
   parameter int unsigned FW_W        = 4,
   parameter int unsigned PW_W        = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             burst_i,
   input  logic [LEN_W-1:0] burst_len_i,
   input  logic             write_i,
   input  logic             ready_mode_i,
   input  logic [FW_W-1:0]  first_wait_i,
   input  logic [PW_W-1:0]  page_wait_i,
   input  logic             rdy_pin_i,
   output logic             ce_n_o,
   output logic             oe_n_o,
   output logic             we_n_o,
   output logic [LEN_W-1:0] beat_addr_o,
   output logic             ack_n_o,
   output logic             ack_oe_o,
   output logic             done_o,
   output logic             reject_o
);

   localparam int unsigned CNT_W = rdy_count_width(FW_W, PW_W);

   generate
      if (FW_W < 2) begin : g_bad_fw
         $error("ebus_wait_seq: FW_W must be at least 2");
      end
      if (PW_W < 1) begin : g_bad_pw
         $error("ebus_wait_seq: PW_W must be positive");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("ebus_wait_seq: LEN_W must be positive");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             rdy_mode_q, write_q, dyn_q;
   logic [PW_W-1:0]  pw_q;
   logic [LEN_W-1:0] last_q;
   logic             reject_q;

   logic             rdy_sync;
   logic             wait_zero;
   logic             at_last;
   logic             in_access;
   logic             accept;
   logic             refuse;
   logic             beat_end;
   logic             finish;
   logic             next_beat;
   logic             wait_load;
   logic [CNT_W-1:0] wait_val;
   logic [CNT_W-1:0] first_val;

   assign in_access = (state_q == SEQ_ACCESS);
   assign refuse    = (state_q == SEQ_IDLE) && req_i && ready_mode_i && burst_i;
   assign accept    = (state_q == SEQ_IDLE) && req_i && !(ready_mode_i && burst_i);

   // The ready-mode count drops the pin-select bit and keeps an even weight.
   assign first_val = ready_mode_i
                    ? {page_wait_i, first_wait_i[FW_W-1:1], 1'b0}
                    : {{PW_W{1'b0}}, first_wait_i};

   assign beat_end  = in_access && wait_zero && (!rdy_mode_q || rdy_sync);
   assign finish    = beat_end && (rdy_mode_q || at_last);
   assign next_beat = beat_end && !finish;
   assign wait_load = accept || next_beat;
   assign wait_val  = accept ? first_val : {{FW_W{1'b0}}, pw_q};

   ebus_rdy_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (rdy_pin_i),
      .sync_o  (rdy_sync)
   );

   ebus_wait_cnt #(
      .CNT_W (CNT_W)
   ) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wait_load),
      .load_val_i (wait_val),
      .dec_i      (in_access),
      .zero_o     (wait_zero)
   );

   ebus_beat_cnt #(
      .LEN_W (LEN_W)
   ) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (accept),
      .step_i    (next_beat),
      .last_i    (last_q),
      .beat_o    (beat_addr_o),
      .at_last_o (at_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:   if (accept) state_d = SEQ_ACCESS;
         SEQ_ACCESS: if (finish) state_d = SEQ_DONE;
         SEQ_DONE:   state_d = SEQ_IDLE;
         default:    state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         rdy_mode_q <= 1'b1;
         write_q    <= 1'b0;
         dyn_q      <= 1'b0;
         pw_q       <= '0;
         last_q     <= '0;
         reject_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         reject_q <= refuse;
         if (accept) begin
            rdy_mode_q <= ready_mode_i;
            write_q    <= write_i;
            dyn_q      <= first_wait_i[0];
            pw_q       <= page_wait_i;
            last_q     <= burst_i ? burst_len_i : '0;
         end
      end
   end

   assign ce_n_o   = !in_access;
   assign oe_n_o   = !(in_access && !write_q);
   assign we_n_o   = !(in_access && write_q);
   assign ack_oe_o = !rdy_mode_q && dyn_q;
   assign ack_n_o  = !(in_access && !rdy_mode_q && dyn_q && wait_zero);
   assign done_o   = (state_q == SEQ_DONE);
   assign reject_o = reject_q;

endmodule

// File: rtl/ebus_wait_seq_chk.sv
module ebus_wait_seq_chk #(
   parameter int unsigned LEN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n_o,
   input logic             oe_n_o,
   input logic             we_n_o,
   input logic [LEN_W-1:0] beat_addr_o,
   input logic             ack_n_o,
   input logic             ack_oe_o,
   input logic             done_o,
   input logic             reject_o
);

   assert_strobe_in_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n_o || !we_n_o) |-> !ce_n_o);

   assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n_o && !we_n_o));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ce_n_o && oe_n_o && we_n_o && $past(!ce_n_o)));

   assert_ack_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n_o |-> (ack_oe_o && !ce_n_o));

   assert_ack_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n_o |=> (ack_n_o || ce_n_o || $changed(beat_addr_o)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_o && $past(!ce_n_o)) |->
         (beat_addr_o == $past(beat_addr_o) || beat_addr_o == $past(beat_addr_o) + 1'b1));

   assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reject_o |-> (ce_n_o && !done_o));

endmodule

bind ebus_wait_seq ebus_wait_seq_chk #(
   .LEN_W (LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n_o      (ce_n_o),
   .oe_n_o      (oe_n_o),
   .we_n_o      (we_n_o),
   .beat_addr_o (beat_addr_o),
   .ack_n_o     (ack_n_o),
   .ack_oe_o    (ack_oe_o),
   .done_o      (done_o),
   .reject_o    (reject_o)
);

// File: tb/tb_ebus_wait_seq.sv
module tb_ebus_wait_seq;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_i = 1'b0;
   logic             burst_i = 1'b0;
   logic [LEN_W-1:0] burst_len_i = '0;
   logic             write_i = 1'b0;
   logic             ready_mode_i = 1'b0;
   logic [3:0]       first_wait_i = '0;
   logic [1:0]       page_wait_i = '0;
   logic             rdy_pin_i = 1'b0;
   logic             ce_n_o, oe_n_o, we_n_o, ack_n_o, ack_oe_o, done_o, reject_o;
   logic [LEN_W-1:0] beat_addr_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ebus_wait_seq #(.LEN_W(LEN_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .burst_i(burst_i),
      .burst_len_i(burst_len_i), .write_i(write_i), .ready_mode_i(ready_mode_i),
      .first_wait_i(first_wait_i), .page_wait_i(page_wait_i), .rdy_pin_i(rdy_pin_i),
      .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o), .beat_addr_o(beat_addr_o),
      .ack_n_o(ack_n_o), .ack_oe_o(ack_oe_o), .done_o(done_o), .reject_o(reject_o)
   );

   typedef struct packed {
      logic       rmode;
      logic       burst;
      logic [2:0] len;
      logic       wr;
      logic [3:0] fw;
      logic [1:0] pw;
      logic [6:0] exp_ce;
      logic [3:0] exp_ack;
      logic [2:0] exp_addr;
      logic       exp_aoe;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 7'd1,  4'd0, 3'd0, 1'b0},
      '{1'b0, 1'b0, 3'd0, 1'b1, 4'd15, 2'd3, 7'd16, 4'd1, 3'd0, 1'b1},
      '{1'b0, 1'b1, 3'd3, 1'b0, 4'd5,  2'd2, 7'd15, 4'd4, 3'd3, 1'b1},
      '{1'b0, 1'b1, 3'd1, 1'b1, 4'd2,  2'd0, 7'd4,  4'd0, 3'd1, 1'b0},
      '{1'b0, 1'b1, 3'd7, 1'b0, 4'd1,  2'd3, 7'd30, 4'd8, 3'd7, 1'b1},
      '{1'b0, 1'b0, 3'd5, 1'b0, 4'd3,  2'd1, 7'd4,  4'd1, 3'd0, 1'b1},
      '{1'b1, 1'b0, 3'd0, 1'b0, 4'd0,  2'd0, 7'd1,  4'd0, 3'd0, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b1, 4'd7,  2'd0, 7'd7,  4'd0, 3'd0, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b0, 4'd15, 2'd3, 7'd63, 4'd0, 3'd0, 1'b0},
      '{1'b1, 1'b0, 3'd0, 1'b1, 4'd4,  2'd1, 7'd21, 4'd0, 3'd0, 1'b0}
   };

   int r_ce, r_ack, r_addr, r_aoe, r_bad_strobe, r_done, r_done_clean;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic run_acc(input bit rm, input bit bu, input logic [2:0] ln, input bit wr,
                          input logic [3:0] fw, input logic [1:0] pw,
                          input int rdy_after, input int poke_at);
      @(negedge clk);
      rdy_pin_i = (rdy_after < 0);
      repeat (3) @(negedge clk);
      ready_mode_i = rm; burst_i = bu; burst_len_i = ln; write_i = wr;
      first_wait_i = fw; page_wait_i = pw; req_i = 1'b1;
      r_ce = 0; r_ack = 0; r_addr = 0; r_aoe = 0; r_bad_strobe = 0;
      r_done = 0; r_done_clean = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         req_i = 1'b0;
         if (!ce_n_o) begin
            r_ce++;
            r_addr = beat_addr_o;
            r_aoe |= ack_oe_o;
            if (oe_n_o != wr || we_n_o != !wr) r_bad_strobe++;
         end
         if (!ack_n_o) r_ack++;
         if (done_o) begin
            r_done = 1;
            r_done_clean = ce_n_o && oe_n_o && we_n_o;
            break;
         end
         if (rdy_after >= 0 && r_ce == rdy_after) rdy_pin_i = 1'b1;
         if (poke_at >= 0 && r_ce == poke_at) begin
            ready_mode_i = 1'b0; burst_i = 1'b1; burst_len_i = 3'd7;
            first_wait_i = 4'd9; req_i = 1'b1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs during and after reset
      chk(ce_n_o && oe_n_o && we_n_o && ack_n_o, "R1 strobes high", {ce_n_o,oe_n_o,we_n_o,ack_n_o}, 15);
      chk(!done_o && !reject_o && !ack_oe_o, "R1 flags low", {done_o,reject_o,ack_oe_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(beat_addr_o == 0 && ce_n_o, "R1 addr zero", beat_addr_o, 0);

      for (int v = 0; v < NVEC; v++) begin
         run_acc(VECS[v].rmode, VECS[v].burst, VECS[v].len, VECS[v].wr,
                 VECS[v].fw, VECS[v].pw, -1, -1);
         // R2 R3 R7: access length from the wait fields
         chk(r_ce == VECS[v].exp_ce, VECS[v].rmode ? "R7 ready wait length" : "R2 R3 page length",
             r_ce, VECS[v].exp_ce);
         chk(r_addr == VECS[v].exp_addr, "R4 final beat address", r_addr, VECS[v].exp_addr);
         chk(r_bad_strobe == 0, "R5 strobe during access", r_bad_strobe, 0);
         chk(r_done == 1 && r_done_clean == 1, "R5 done with strobes released", r_done_clean, 1);
         chk(r_ack == VECS[v].exp_ack, "R6 ack pulse count", r_ack, VECS[v].exp_ack);
         chk(r_aoe == VECS[v].exp_aoe, "R6 pin drive enable", r_aoe, VECS[v].exp_aoe);
         @(negedge clk);
         chk(!done_o && ce_n_o, "R5 done one cycle", done_o, 0);
         chk(beat_addr_o == VECS[v].exp_addr, "R4 address holds after access", beat_addr_o, VECS[v].exp_addr);
      end

      // R8: late ready, wait 2, pin raised after 5th low cycle -> 7 low cycles
      run_acc(1'b1, 1'b0, 3'd0, 1'b0, 4'd2, 2'd0, 5, -1);
      chk(r_ce == 7, "R8 synchronizer latency", r_ce, 7);
      chk(r_done == 1, "R8 done after ready", r_done, 1);

      // R9: early ready, wait 6, pin raised after 1st cycle -> still 7
      run_acc(1'b1, 1'b0, 3'd0, 1'b1, 4'd6, 2'd0, 1, -1);
      chk(r_ce == 7, "R9 early ready ignored", r_ce, 7);

      // R10: burst refused in ready mode
      @(negedge clk);
      rdy_pin_i = 1'b1;
      ready_mode_i = 1'b1; burst_i = 1'b1; burst_len_i = 3'd3; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      chk(reject_o == 1'b1, "R10 reject pulse", reject_o, 1);
      chk(ce_n_o && oe_n_o && we_n_o, "R10 no strobes", ce_n_o, 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!reject_o && ce_n_o && !done_o, "R10 stays idle", {reject_o,ce_n_o,done_o}, 2);
      end

      // R11: request during a page access with fw=3 is ignored
      run_acc(1'b0, 1'b0, 3'd0, 1'b0, 4'd3, 2'd0, -1, 2);
      chk(r_ce == 4, "R11 running access unchanged", r_ce, 4);
      chk(r_addr == 0, "R11 address unchanged", r_addr, 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(ce_n_o && !done_o, "R11 no second access", ce_n_o, 1);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule